// File: doc/BRIEF.md
# Nibble-Wide Receive Sync Hunter

This block sits at the entry of a media-independent receive path. It watches a 4-bit receive data bus that is qualified by a data-valid strobe, and it searches the incoming nibble stream for a programmable 16-bit synchronization pattern. Once the pattern has been seen, it stops searching and pairs the nibbles that follow into bytes for the next stage. It marks the first byte of each frame with a start pulse, and it marks the loss of carrier with an end pulse.

The search starts only when the receiver is enabled and data-valid is high. In half-duplex operation, an asserted collision input also holds the search off. In full-duplex operation, the collision input plays no part. Address filtering, CRC checking and buffer transfer belong to downstream logic.

Top module: `rxSyncHunter`

## Requirements
- R1: While reset is held, and right after it is released, `byteValid`, `frameStart` and `frameEnd` are low.
- R2: In half-duplex mode (`fullDuplex` = 0), no search begins while `collision` is high. A pattern sent with collision held high therefore produces no bytes.
- R3: In full-duplex mode (`fullDuplex` = 1), `collision` is ignored. A pattern sent with collision held high is found, and the bytes after it are delivered.
- R4: The search shifts in one nibble per valid clock and compares the last four nibbles with `syncPattern`. The oldest of those nibbles is compared with bits [15:12] and the newest with bits [3:0]. The same nibbles in reverse order do not match.
- R5: A match counts only after at least four nibbles have been shifted in since the search began. Cleared register contents never complete a pattern.
- R6: If `rxValid` drops during the search, the collected nibbles are discarded and the block waits for `rxValid` to rise again.
- R7: After a match, the first valid nibble becomes the low half of a byte and the next valid nibble becomes the high half. `byteValid` pulses with `byteData` on the clock edge that samples the high nibble. Two strobes never occur on consecutive cycles.
- R8: `frameStart` pulses together with the first byte after each match, and only with that byte.
- R9: While bytes are being assembled, a low `carrierSense` ends the frame. `frameEnd` pulses for exactly one cycle on the edge that samples the drop, a pending half byte is discarded, and the block returns to idle.
- R10: During assembly, cycles with `rxValid` low are skipped and do not advance the nibble pairing.
- R11: With `rxEnable` low, no search begins and no bytes are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable |
| fullDuplex | input | 1 | 1 = full duplex (collision ignored) |
| rxData | input | 4 | Receive data nibble |
| rxValid | input | 1 | Receive data valid |
| collision | input | 1 | Collision indication |
| carrierSense | input | 1 | Carrier present |
| syncPattern | input | 16 | Sync pattern, oldest nibble in [15:12] |
| byteValid | output | 1 | Assembled byte strobe |
| byteData | output | 8 | Assembled byte, first nibble in [3:0] |
| frameStart | output | 1 | Pulses with the first byte of a frame |
| frameEnd | output | 1 | Pulses when carrier drops during assembly |

## Verification
The hardest case to reach from the ports is a stream that would match only if stale or cleared shift-register contents were counted. The directed stimulus covers this in two ways. It sends a pattern whose leading nibbles are zero, so a matcher that ignored the fill count would fire early. It also splits a valid pattern across a drop of `rxValid`, so a matcher that kept its contents would wrongly lock. In both cases the bench expects no bytes. It then sends the complete pattern and confirms that the search still works.

// File: rtl/rxHuntPkg.sv
package rxHuntPkg;

  typedef enum logic [1:0] {
    HUNT_IDLE     = 2'd0,
    HUNT_SEARCH   = 2'd1,
    HUNT_ASSEMBLE = 2'd2
  } huntState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // shift current nibble into the search window
    logic shiftClr;  // empty the search window and its fill count
    logic frameClr;  // new frame: reset nibble pairing and first-byte flag
    logic nibTake;   // accept current nibble into byte assembly
    logic endPulse;  // carrier lost during assembly
  } huntCtrl_t;

endpackage

// File: rtl/rxHuntCtrl.sv
module rxHuntCtrl
  import rxHuntPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      fullDuplex,
  input  logic      rxValid,
  input  logic      collision,
  input  logic      carrierSense,
  input  logic      syncHit,
  output huntCtrl_t ctrl
);

  huntState_t state, nextState;
  logic       enterOk;
  logic       keepHunting;

  // Entry gate: collision only matters in half duplex
  assign enterOk     = rxEnable && rxValid && (fullDuplex || !collision);
  assign keepHunting = rxEnable && rxValid;

  always_ff @(posedge clk) begin
    if (!rstN) state <= HUNT_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      HUNT_IDLE: begin
        if (enterOk) begin
          ctrl.shiftEn = 1'b1;
          if (syncHit) begin
            ctrl.frameClr = 1'b1;
            nextState     = HUNT_ASSEMBLE;
          end else begin
            nextState = HUNT_SEARCH;
          end
        end else begin
          ctrl.shiftClr = 1'b1;
        end
      end
      HUNT_SEARCH: begin
        if (keepHunting) begin
          ctrl.shiftEn = 1'b1;
          if (syncHit) begin
            ctrl.frameClr = 1'b1;
            nextState     = HUNT_ASSEMBLE;
          end
        end else begin
          ctrl.shiftClr = 1'b1;
          nextState     = HUNT_IDLE;
        end
      end
      HUNT_ASSEMBLE: begin
        if (!carrierSense) begin
          ctrl.endPulse = 1'b1;
          ctrl.shiftClr = 1'b1;
          nextState     = HUNT_IDLE;
        end else if (rxValid) begin
          ctrl.nibTake = 1'b1;
        end
      end
      default: nextState = HUNT_IDLE;
    endcase
  end

endmodule

// File: rtl/rxHuntDatapath.sv
module rxHuntDatapath
  import rxHuntPkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int SYNC_NIBBLES = 4,
  localparam int SYNC_W      = NIB_W * SYNC_NIBBLES,
  localparam int BYTE_W      = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  huntCtrl_t         ctrl,
  input  logic [NIB_W-1:0]  rxData,
  input  logic [SYNC_W-1:0] syncPattern,
  output logic              syncHit,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              frameStart,
  output logic              frameEnd
);

  localparam int FILL_W = $clog2(SYNC_NIBBLES + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SYNC_NIBBLES);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SYNC_NIBBLES - 1);

  logic [SYNC_W-1:0]       window;
  logic [SYNC_W-1:0]       windowNext;
  logic [FILL_W-1:0]       fillCount;
  logic [SYNC_NIBBLES-1:0] nibMatch;
  logic                    highPhase;
  logic                    firstPending;
  logic [NIB_W-1:0]        lowNib;
  logic                    completeByte;

  // Window as it stands after the current shift; newest nibble lowest
  assign windowNext = {window[SYNC_W-NIB_W-1:0], rxData};

  for (genvar i = 0; i < SYNC_NIBBLES; i++) begin : g_nibCmp
    assign nibMatch[i] = (windowNext[i*NIB_W +: NIB_W] == syncPattern[i*NIB_W +: NIB_W]);
  end

  // Valid only once a full window of real nibbles has arrived
  assign syncHit = (fillCount >= FILL_LAST) && (&nibMatch);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.shiftClr) begin
      window    <= '0;
      fillCount <= '0;
    end else if (ctrl.shiftEn) begin
      window <= windowNext;
      if (fillCount != FILL_FULL) fillCount <= fillCount + 1'b1;
    end
  end

  assign completeByte = ctrl.nibTake && highPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highPhase    <= 1'b0;
      firstPending <= 1'b0;
      lowNib       <= '0;
    end else if (ctrl.frameClr) begin
      highPhase    <= 1'b0;
      firstPending <= 1'b1;
    end else if (ctrl.nibTake) begin
      highPhase <= !highPhase;
      if (!highPhase) lowNib <= rxData;
      else            firstPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteValid  <= 1'b0;
      byteData   <= '0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      byteValid  <= completeByte;
      frameStart <= completeByte && firstPending;
      frameEnd   <= ctrl.endPulse;
      if (completeByte) byteData <= {rxData, lowNib};
    end
  end

endmodule

// File: rtl/rxSyncHunter.sv
module rxSyncHunter
  import rxHuntPkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int SYNC_NIBBLES = 4,
  localparam int SYNC_W      = NIB_W * SYNC_NIBBLES,
  localparam int BYTE_W      = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              fullDuplex,
  input  logic [NIB_W-1:0]  rxData,
  input  logic              rxValid,
  input  logic              collision,
  input  logic              carrierSense,
  input  logic [SYNC_W-1:0] syncPattern,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              frameStart,
  output logic              frameEnd
);

  huntCtrl_t ctrl;
  logic      syncHit;

  rxHuntCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxEnable     (rxEnable),
    .fullDuplex   (fullDuplex),
    .rxValid      (rxValid),
    .collision    (collision),
    .carrierSense (carrierSense),
    .syncHit      (syncHit),
    .ctrl         (ctrl)
  );

  rxHuntDatapath #(
    .NIB_W        (NIB_W),
    .SYNC_NIBBLES (SYNC_NIBBLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .rxData      (rxData),
    .syncPattern (syncPattern),
    .syncHit     (syncHit),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .frameStart  (frameStart),
    .frameEnd    (frameEnd)
  );

endmodule

// File: rtl/rxSyncHunterChk.sv
module rxSyncHunterChk (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic carrierSense,
  input logic byteValid,
  input logic frameStart,
  input logic frameEnd
);

  AST_START_WITH_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> byteValid); // R8

  AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R7

  AST_BYTE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(rxValid)); // R10

  AST_END_AFTER_CRS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> !$past(carrierSense)); // R9

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd); // R9

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rstN |=> !byteValid && !frameStart && !frameEnd); // R1

endmodule

bind rxSyncHunter rxSyncHunterChk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rxValid      (rxValid),
  .carrierSense (carrierSense),
  .byteValid    (byteValid),
  .frameStart   (frameStart),
  .frameEnd     (frameEnd)
);

// File: tb/tb_rxSyncHunter.sv
`timescale 1ns/1ps
module tb_rxSyncHunter;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rxEnable;
  logic        fullDuplex;
  logic [3:0]  rxData;
  logic        rxValid;
  logic        collision;
  logic        carrierSense;
  logic [15:0] syncPattern;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        frameStart;
  logic        frameEnd;

  int checks = 0;
  int errors = 0;

  logic [7:0] gotBytes[$];
  int nStarts;
  int nEnds;
  int firstStartIdx;

  always #4 clk = !clk;  // 125 MHz

  rxSyncHunter dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fullDuplex(fullDuplex),
    .rxData(rxData), .rxValid(rxValid), .collision(collision),
    .carrierSense(carrierSense), .syncPattern(syncPattern),
    .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd)
  );

  // Output log, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (frameStart) begin
        nStarts++;
        if (firstStartIdx < 0) firstStartIdx = gotBytes.size();
      end
      if (byteValid) gotBytes.push_back(byteData);
      if (frameEnd) nEnds++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    gotBytes.delete();
    nStarts = 0;
    nEnds = 0;
    firstStartIdx = -1;
  endtask

  task automatic sendNib(input logic [3:0] d, input logic v, input logic crs);
    @(negedge clk);
    rxData = d;
    rxValid = v;
    carrierSense = crs;
    @(posedge clk);
    #1;
  endtask

  task automatic sendHex(input logic [63:0] h, input int n);
    for (int i = n - 1; i >= 0; i--) sendNib(h[i*4 +: 4], 1'b1, 1'b1);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendNib(b[3:0], 1'b1, 1'b1);
    sendNib(b[7:4], 1'b1, 1'b1);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) sendNib(4'h0, 1'b0, 1'b0);
  endtask

  function automatic int byteAt(input int idx);
    if (gotBytes.size() > idx) return int'(gotBytes[idx]);
    return -1;
  endfunction

  task automatic tBasic();
    clearLog();
    syncPattern = 16'h555D;
    sendHex(64'h5555555D, 8);
    check(byteValid == 1'b0, "R4 no byte on sync nibble", byteValid, 0);
    sendNib(4'hC, 1'b1, 1'b1);
    check(byteValid == 1'b0, "R7 no strobe on low nibble", byteValid, 0);
    sendNib(4'h3, 1'b1, 1'b1);
    check(byteValid == 1'b1 && byteData == 8'h3C, "R7 first byte low nibble first", byteData, 8'h3C);
    check(frameStart == 1'b1, "R8 start with first byte", frameStart, 1);
    sendByte(8'hA7);
    check(frameStart == 1'b0, "R8 no start on second byte", frameStart, 0);
    sendByte(8'h01);
    sendNib(4'h0, 1'b0, 1'b0);
    check(frameEnd == 1'b1, "R9 end on carrier drop", frameEnd, 1);
    sendNib(4'h0, 1'b0, 1'b0);
    check(frameEnd == 1'b0, "R9 end lasts one cycle", frameEnd, 0);
    check(gotBytes.size() == 3, "R7 byte count", gotBytes.size(), 3);
    check(byteAt(1) == 8'hA7 && byteAt(2) == 8'h01, "R7 byte values", byteAt(2), 8'h01);
    check(nStarts == 1 && firstStartIdx == 0, "R8 single start on first byte", nStarts, 1);
    check(nEnds == 1, "R9 single end", nEnds, 1);
  endtask

  task automatic tPattern();
    clearLog();
    syncPattern = 16'hA3C1;
    sendHex(64'h1C3A, 4);
    sendByte(8'h66);
    sendByte(8'h99);
    quiet(2);
    check(gotBytes.size() == 0, "R4 reversed order ignored", gotBytes.size(), 0);
    clearLog();
    sendHex(64'hA3C1, 4);
    sendByte(8'h5E);
    quiet(2);
    check(byteAt(0) == 8'h5E && gotBytes.size() == 1, "R4 exact order matches", byteAt(0), 8'h5E);
  endtask

  task automatic tPartialWindow();
    clearLog();
    syncPattern = 16'h005D;
    sendHex(64'h5D12, 4);
    sendByte(8'h44);
    quiet(2);
    check(gotBytes.size() == 0, "R5 cleared window never matches", gotBytes.size(), 0);
    clearLog();
    sendHex(64'h005D, 4);
    sendByte(8'h81);
    quiet(2);
    check(byteAt(0) == 8'h81, "R5 full window matches", byteAt(0), 8'h81);
  endtask

  task automatic tValidDrop();
    clearLog();
    syncPattern = 16'hA3C1;
    sendHex(64'hA3, 2);
    sendNib(4'h0, 1'b0, 1'b1);
    sendHex(64'hC1, 2);
    sendByte(8'h77);
    quiet(2);
    check(gotBytes.size() == 0, "R6 drop discards window", gotBytes.size(), 0);
    check(nEnds == 0, "R9 no end outside assembly", nEnds, 0);
  endtask

  task automatic tCollision(input logic fd);
    clearLog();
    syncPattern = 16'h555D;
    fullDuplex = fd;
    collision = 1'b1;
    sendHex(64'h555D, 4);
    sendByte(8'h2B);
    sendByte(8'hF0);
    quiet(2);
    collision = 1'b0;
    fullDuplex = 1'b0;
    if (fd)
      check(gotBytes.size() == 2 && byteAt(1) == 8'hF0, "R3 full duplex ignores collision", byteAt(1), 8'hF0);
    else
      check(gotBytes.size() == 0, "R2 half duplex collision blocks hunt", gotBytes.size(), 0);
  endtask

  task automatic tDisabled();
    clearLog();
    syncPattern = 16'h555D;
    rxEnable = 1'b0;
    sendHex(64'h555D, 4);
    sendByte(8'h12);
    quiet(2);
    rxEnable = 1'b1;
    check(gotBytes.size() == 0 && nStarts == 0, "R11 disabled receiver quiet", gotBytes.size(), 0);
  endtask

  task automatic tGap();
    clearLog();
    syncPattern = 16'h555D;
    sendHex(64'h555D, 4);
    sendNib(4'hC, 1'b1, 1'b1);
    sendNib(4'h0, 1'b0, 1'b1);
    check(byteValid == 1'b0, "R10 gap gives no strobe", byteValid, 0);
    sendNib(4'h3, 1'b1, 1'b1);
    check(byteValid == 1'b1 && byteData == 8'h3C, "R10 gap skipped in pairing", byteData, 8'h3C);
    quiet(2);
  endtask

  task automatic tOddEnd();
    clearLog();
    syncPattern = 16'h555D;
    sendHex(64'h555D, 4);
    sendByte(8'h42);
    sendNib(4'h9, 1'b1, 1'b1);
    sendNib(4'h0, 1'b0, 1'b0);
    check(frameEnd == 1'b1 && byteValid == 1'b0, "R9 end drops half byte", frameEnd, 1);
    quiet(2);
    check(gotBytes.size() == 1 && byteAt(0) == 8'h42, "R9 only whole bytes kept", gotBytes.size(), 1);
  endtask

  initial begin
    rstN = 1'b0;
    rxEnable = 1'b1;
    fullDuplex = 1'b0;
    rxData = '0;
    rxValid = 1'b0;
    collision = 1'b0;
    carrierSense = 1'b0;
    syncPattern = 16'h555D;
    clearLog();
    repeat (3) @(posedge clk);
    #1;
    check(!byteValid && !frameStart && !frameEnd, "R1 outputs low in reset",
          {byteValid, frameStart, frameEnd}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(!byteValid && !frameStart && !frameEnd, "R1 outputs low after reset",
          {byteValid, frameStart, frameEnd}, 0);
    tBasic();
    tPattern();
    tPartialWindow();
    tValidDrop();
    tCollision(1'b0);
    tCollision(1'b1);
    tDisabled();
    tGap();
    tOddEnd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule